// File: doc/BRIEF.md
# Port Bus-Width Matching Serializer

This block sits between a 36-bit memory word and an external data port whose width can be 36, 18 or 9 bits. A two-bit width select picks the port width. An endian select picks whether the least or the most significant piece of the word moves first. An internal piece counter steps through the pieces of one word, one piece per port transfer. It returns to zero after the last piece, or when the address logic signals that a new address has been loaded.

On reads, the block slices the memory word held at the current address and drives the selected piece on the low port lanes. Each lane has its own output enable, and the enables of unused lanes stay low. On writes, it collects the incoming pieces into a holding register. Only when the last piece arrives does it hand the complete word to the memory side, with a one-cycle commit strobe.

The memory array and the address counter are outside this block. The block reports the last transfer of each word so that the address logic can advance.

Top module: `bm_serializer`

## Requirements
- R1: After reset, all port lane enables, the memory commit strobe and the word-done flag are low, and the piece counter is zero.
- R2: With width select 2'b00 (36-bit), every transfer is the last piece. A read transfer drives memory bits 35..0 on port lanes 35..0, with all 36 lane enables high.
- R3: With width select 2'b01 (18-bit), a word takes two transfers on lanes 17..0. In little-endian order the first transfer carries memory bits 17..0 and the second carries bits 35..18. Lanes 35..18 are driven with zero and have their enables low.
- R4: With width select 2'b10 or 2'b11 (9-bit), a word takes four transfers on lanes 8..0. In little-endian order they carry memory bits 8..0, 17..9, 26..18 and 35..27. Lanes 35..9 are zero and have their enables low.
- R5: With big_endian high, the piece order is reversed, so the most significant piece moves first. This holds for reads and writes in every width.
- R6: The piece counter advances only on a cycle with xfer_en high, and wraps to zero after the last piece. word_done is high exactly during the transfer of the last piece. Idle cycles hold the counter.
- R7: load forces the piece counter to zero. A transfer in the same cycle as load uses piece zero, so a partly moved word is abandoned.
- R8: A write transfer of the last piece raises mem_we one cycle later, with mem_wdata equal to the assembled word. Earlier pieces never raise mem_we.
- R9: Lane enables are all low in any cycle that is not a read transfer (xfer_en high, wr low).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode | input | 2 | Width select: 00 = 36-bit, 01 = 18-bit, 10/11 = 9-bit |
| big_endian | input | 1 | 1 = most significant piece first |
| load | input | 1 | New address loaded; clears the piece counter |
| xfer_en | input | 1 | A port transfer happens this cycle |
| wr | input | 1 | 1 = write transfer, 0 = read transfer |
| port_din | input | 36 | Write data from the port, on the low lanes |
| port_dout | output | 36 | Read data to the port |
| port_oe | output | 36 | Per-lane output enable |
| word_done | output | 1 | The current transfer is the last piece of the word |
| mem_rdata | input | 36 | Memory word at the current address |
| mem_wdata | output | 36 | Assembled word to commit |
| mem_we | output | 1 | Commit strobe, one cycle after the last write piece |

## Verification
Read data, lane enables and word_done depend on the inputs of the same cycle without passing a register. The bench therefore drives a transfer on a falling edge and samples these outputs shortly after, before the next rising edge. mem_we and mem_wdata come out one rising edge after the last write piece, so the bench checks them at the falling edge that follows, and checks mem_we low at the same point after every earlier piece. The order of the counter after an idle gap and after a load is seen only through the piece that the next read transfer drives.

// File: rtl/bm_pkg.sv
package bm_pkg;

   typedef enum logic [1:0] {
      BM_W36  = 2'b00,
      BM_W18  = 2'b01,
      BM_W9   = 2'b10,
      BM_W9B  = 2'b11
   } bm_width_e;

   // index of the final piece of a word for a given width select
   function automatic logic [1:0] final_piece(input logic [1:0] sel);
      case (bm_width_e'(sel))
         BM_W36:  final_piece = 2'd0;
         BM_W18:  final_piece = 2'd1;
         default: final_piece = 2'd3;
      endcase
   endfunction

endpackage

// File: rtl/bm_subcnt.sv
module bm_subcnt #(
   parameter int CNT_W = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic             xfer_en,
   input  logic [CNT_W-1:0] last_idx,
   output logic [CNT_W-1:0] piece_idx,
   output logic             is_last
);

   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] eff;

   // a load in the same cycle makes this transfer piece zero
   always_comb begin
      eff       = load ? '0 : cnt_q;
      piece_idx = eff;
      is_last   = (eff == last_idx);
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (xfer_en) begin
         cnt_q <= is_last ? '0 : eff + 1'b1;
      end else if (load) begin
         cnt_q <= '0;
      end
   end

endmodule

// File: rtl/bm_rd_mux.sv
module bm_rd_mux #(
   parameter int LANE_W = 9,
   parameter int GROUPS = 4,
   localparam int WORD_W = LANE_W * GROUPS
) (
   input  logic [WORD_W-1:0] rdata,
   input  logic [1:0]        mode,
   input  logic [1:0]        sel,
   input  logic              rd_act,
   output logic [WORD_W-1:0] dout,
   output logic [WORD_W-1:0] oe
);
   import bm_pkg::*;

   logic [LANE_W-1:0] grp [GROUPS];

   for (genvar u = 0; u < GROUPS; u++) begin : g_unpack
      assign grp[u] = rdata[u*LANE_W +: LANE_W];
   end

   for (genvar g = 0; g < GROUPS; g++) begin : g_lane
      logic [1:0] src;
      logic       en;
      always_comb begin
         case (bm_width_e'(mode))
            BM_W36: begin
               src = 2'(g);
               en  = 1'b1;
            end
            BM_W18: begin
               src = {sel[0], 1'(g % 2)};
               en  = (g < GROUPS/2);
            end
            default: begin
               src = sel;
               en  = (g == 0);
            end
         endcase
      end
      assign dout[g*LANE_W +: LANE_W] = (en && rd_act) ? grp[src] : '0;
      assign oe[g*LANE_W +: LANE_W]   = {LANE_W{en && rd_act}};
   end

endmodule

// File: rtl/bm_wr_pack.sv
module bm_wr_pack #(
   parameter int LANE_W = 9,
   parameter int GROUPS = 4,
   localparam int WORD_W = LANE_W * GROUPS
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [WORD_W-1:0] din,
   input  logic [1:0]        mode,
   input  logic [1:0]        sel,
   input  logic              wr_act,
   input  logic              last,
   output logic [WORD_W-1:0] wdata,
   output logic              we
);
   import bm_pkg::*;

   logic [WORD_W-1:0] asm_q;
   logic [WORD_W-1:0] merged;
   logic [WORD_W-1:0] wdata_q;
   logic              we_q;
   logic [LANE_W-1:0] ingrp [GROUPS];

   for (genvar u = 0; u < GROUPS; u++) begin : g_unpack
      assign ingrp[u] = din[u*LANE_W +: LANE_W];
   end

   for (genvar k = 0; k < GROUPS; k++) begin : g_grp
      logic       take;
      logic [1:0] src;
      always_comb begin
         case (bm_width_e'(mode))
            BM_W36: begin
               take = 1'b1;
               src  = 2'(k);
            end
            BM_W18: begin
               take = (sel[0] == 1'(k / 2));
               src  = 2'(k % 2);
            end
            default: begin
               take = (sel == 2'(k));
               src  = 2'd0;
            end
         endcase
      end
      assign merged[k*LANE_W +: LANE_W] =
         (wr_act && take) ? ingrp[src] : asm_q[k*LANE_W +: LANE_W];
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         asm_q   <= '0;
         wdata_q <= '0;
         we_q    <= 1'b0;
      end else begin
         we_q <= wr_act && last;
         if (wr_act) asm_q <= merged;
         if (wr_act && last) wdata_q <= merged;
      end
   end

   assign wdata = wdata_q;
   assign we    = we_q;

endmodule

// File: rtl/bm_serializer.sv
module bm_serializer #(
   parameter int LANE_W = 9,
   parameter int GROUPS = 4,
   parameter int WORD_W = 36
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [1:0]        mode,
   input  logic              big_endian,
   input  logic              load,
   input  logic              xfer_en,
   input  logic              wr,
   input  logic [WORD_W-1:0] port_din,
   output logic [WORD_W-1:0] port_dout,
   output logic [WORD_W-1:0] port_oe,
   output logic              word_done,
   input  logic [WORD_W-1:0] mem_rdata,
   output logic [WORD_W-1:0] mem_wdata,
   output logic              mem_we
);

   if (WORD_W != LANE_W * GROUPS) begin : g_bad_word
      $error("bm_serializer: WORD_W must equal LANE_W*GROUPS");
   end
   if (GROUPS != 4) begin : g_bad_groups
      $error("bm_serializer: three widths need exactly four lane groups");
   end
   if (LANE_W < 1) begin : g_bad_lane
      $error("bm_serializer: LANE_W must be positive");
   end

   logic [1:0] last_i;
   logic [1:0] idx;
   logic [1:0] sel;
   logic       is_last;
   logic       rd_act;
   logic       wr_act;

   assign last_i = bm_pkg::final_piece(mode);
   // reversed order maps count n to piece (last - n)
   assign sel    = big_endian ? (last_i - idx) : idx;
   assign rd_act = xfer_en && !wr;
   assign wr_act = xfer_en && wr;

   bm_subcnt #(.CNT_W(2)) u_cnt (
      .clk       (clk),
      .rst_n     (rst_n),
      .load      (load),
      .xfer_en   (xfer_en),
      .last_idx  (last_i),
      .piece_idx (idx),
      .is_last   (is_last)
   );

   bm_rd_mux #(.LANE_W(LANE_W), .GROUPS(GROUPS)) u_rd (
      .rdata  (mem_rdata),
      .mode   (mode),
      .sel    (sel),
      .rd_act (rd_act),
      .dout   (port_dout),
      .oe     (port_oe)
   );

   bm_wr_pack #(.LANE_W(LANE_W), .GROUPS(GROUPS)) u_wr (
      .clk    (clk),
      .rst_n  (rst_n),
      .din    (port_din),
      .mode   (mode),
      .sel    (sel),
      .wr_act (wr_act),
      .last   (is_last),
      .wdata  (mem_wdata),
      .we     (mem_we)
   );

   assign word_done = xfer_en && is_last;

endmodule

// File: rtl/bm_serializer_chk.sv
module bm_serializer_chk #(
   parameter int WORD_W = 36,
   parameter int LANE_W = 9
) (
   input logic              clk,
   input logic              rst_n,
   input logic [1:0]        mode,
   input logic              xfer_en,
   input logic              wr,
   input logic [WORD_W-1:0] port_oe,
   input logic              word_done,
   input logic              mem_we
);

   AST_OE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      !(xfer_en && !wr) |-> (port_oe == '0));                        // R9

   AST_COMMIT_LATE: assert property (@(posedge clk) disable iff (!rst_n)
      (xfer_en && wr && word_done) |=> mem_we);                      // R8

   AST_COMMIT_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_we && $past(rst_n)) |-> $past(xfer_en && wr && word_done)); // R8

   AST_WIDE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      (xfer_en && mode == 2'b00) |-> word_done);                     // R2

   AST_BYTE_LANES: assert property (@(posedge clk) disable iff (!rst_n)
      (mode[1] == 1'b1) |-> (port_oe[WORD_W-1:LANE_W] == '0));       // R4

   AST_HALF_LANES: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == 2'b01) |-> (port_oe[WORD_W-1:WORD_W/2] == '0));       // R3

   AST_DONE_NEEDS_XFER: assert property (@(posedge clk) disable iff (!rst_n)
      word_done |-> xfer_en);                                        // R6

endmodule

bind bm_serializer bm_serializer_chk #(.WORD_W(WORD_W), .LANE_W(LANE_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .mode      (mode),
   .xfer_en   (xfer_en),
   .wr        (wr),
   .port_oe   (port_oe),
   .word_done (word_done),
   .mem_we    (mem_we)
);

// File: tb/bm_serializer_bench.sv
module bm_serializer_bench;

   localparam int CLK_PERIOD = 10;
   localparam int NVEC = 8;
   // fields: [41:40] write width, [39] write big, [38:37] read width, [36] read big, [35:0] word
   localparam logic [41:0] VEC [NVEC] = '{
      {2'b00, 1'b0, 2'b10, 1'b0, 36'h1_2345_6789},
      {2'b10, 1'b0, 2'b01, 1'b0, 36'hA_BCDE_F012},
      {2'b01, 1'b0, 2'b00, 1'b0, 36'h5_A5A5_A5A5},
      {2'b10, 1'b1, 2'b10, 1'b0, 36'h8_0402_0100},
      {2'b01, 1'b1, 2'b10, 1'b1, 36'hF_0F0F_0F0F},
      {2'b10, 1'b0, 2'b01, 1'b1, 36'h3_C3C3_C3C3},
      {2'b00, 1'b0, 2'b11, 1'b1, 36'h9_8765_4321},
      {2'b11, 1'b1, 2'b00, 1'b0, 36'h7_FFFF_0001}
   };

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [1:0]  mode = 2'b00;
   logic        big_endian = 1'b0;
   logic        load = 1'b0;
   logic        xfer_en = 1'b0;
   logic        wr = 1'b0;
   logic [35:0] port_din = '0;
   logic [35:0] port_dout;
   logic [35:0] port_oe;
   logic        word_done;
   logic [35:0] mem_rdata;
   logic [35:0] mem_wdata;
   logic        mem_we;
   logic [35:0] mem_word = '0;

   int checks = 0;
   int errors = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   always_ff @(posedge clk) if (mem_we) mem_word <= mem_wdata;
   assign mem_rdata = mem_word;

   bm_serializer u_bm_serializer (
      .clk(clk), .rst_n(rst_n), .mode(mode), .big_endian(big_endian),
      .load(load), .xfer_en(xfer_en), .wr(wr), .port_din(port_din),
      .port_dout(port_dout), .port_oe(port_oe), .word_done(word_done),
      .mem_rdata(mem_rdata), .mem_wdata(mem_wdata), .mem_we(mem_we)
   );

   function automatic int npieces(input logic [1:0] m);
      return (m == 2'b00) ? 1 : (m == 2'b01) ? 2 : 4;
   endfunction

   function automatic logic [35:0] lane_mask(input logic [1:0] m);
      int w = 36 / npieces(m);
      return (w == 36) ? {36{1'b1}} : ((36'd1 << w) - 36'd1);
   endfunction

   function automatic logic [35:0] exp_piece(input logic [35:0] d, input logic [1:0] m,
                                             input logic be, input int idx);
      int n = npieces(m);
      int w = 36 / n;
      int p = be ? (n - 1 - idx) : idx;
      return (d >> (p * w)) & lane_mask(m);
   endfunction

   function automatic string tag(input logic [1:0] m, input logic be);
      if (be) return "R5";
      return (m == 2'b00) ? "R2" : (m == 2'b01) ? "R3" : "R4";
   endfunction

   task automatic check(input string req, input logic [35:0] act, input logic [35:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic drive(input logic ld, input logic xe, input logic w, input logic [35:0] d);
      @(negedge clk);
      load = ld; xfer_en = xe; wr = w; port_din = d;
      #1;
   endtask

   task automatic write_word(input logic [1:0] m, input logic be, input logic [35:0] d);
      int n = npieces(m);
      mode = m; big_endian = be;
      for (int i = 0; i < n; i++) begin
         drive(i == 0, 1'b1, 1'b1, exp_piece(d, m, be, i));
         if (i > 0) check("R8", {35'd0, mem_we}, 36'd0);
         check("R6", {35'd0, word_done}, {35'd0, i == n - 1});
         check("R9", port_oe, 36'd0);
      end
      drive(1'b0, 1'b0, 1'b0, '0);
      check("R8", {35'd0, mem_we}, 36'd1);
      check({"R8 ", tag(m, be)}, mem_wdata, d);
   endtask

   task automatic read_word(input logic [1:0] m, input logic be, input logic [35:0] d);
      int n = npieces(m);
      mode = m; big_endian = be;
      for (int i = 0; i < n; i++) begin
         drive(i == 0, 1'b1, 1'b0, '0);
         check(tag(m, be), port_dout, exp_piece(d, m, be, i));
         check(tag(m, be), port_oe, lane_mask(m));
         check("R6", {35'd0, word_done}, {35'd0, i == n - 1});
      end
      drive(1'b0, 1'b0, 1'b0, '0);
   endtask

   initial begin : watchdog
      #(CLK_PERIOD * 20000);
      errors++;
      checks++;
      $display("FAIL watchdog actual timeout expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin : main
      repeat (3) @(negedge clk);
      #1;
      // R1: reset state
      check("R1", port_oe, 36'd0);
      check("R1", {34'd0, mem_we, word_done}, 36'd0);
      rst_n = 1'b1;

      for (int v = 0; v < NVEC; v++) begin
         write_word(VEC[v][41:40], VEC[v][39], VEC[v][35:0]);
         drive(1'b0, 1'b0, 1'b0, '0);
         read_word(VEC[v][38:37], VEC[v][36], VEC[v][35:0]);
      end

      // R1: counter is zero after a fresh reset (first read is piece 0, no load)
      mem_word = 36'h6_1234_5ABC;
      drive(1'b0, 1'b0, 1'b0, '0);
      rst_n = 1'b0;
      drive(1'b0, 1'b0, 1'b0, '0);
      rst_n = 1'b1;
      mode = 2'b10; big_endian = 1'b0;
      drive(1'b0, 1'b1, 1'b0, '0);
      check("R1", port_dout, exp_piece(mem_word, 2'b10, 1'b0, 0));

      // R6: idle cycles hold the counter
      drive(1'b0, 1'b0, 1'b0, '0);
      check("R9", port_oe, 36'd0);
      drive(1'b0, 1'b0, 1'b0, '0);
      drive(1'b0, 1'b1, 1'b0, '0);
      check("R6", port_dout, exp_piece(mem_word, 2'b10, 1'b0, 1));

      // R7: load with transfer restarts at piece zero
      drive(1'b1, 1'b1, 1'b0, '0);
      check("R7", port_dout, exp_piece(mem_word, 2'b10, 1'b0, 0));
      drive(1'b0, 1'b1, 1'b0, '0);
      check("R7", port_dout, exp_piece(mem_word, 2'b10, 1'b0, 1));

      // R7: load alone, then transfer gets piece zero in big-endian order
      big_endian = 1'b1;
      drive(1'b1, 1'b0, 1'b0, '0);
      drive(1'b0, 1'b1, 1'b0, '0);
      check("R7", port_dout, exp_piece(mem_word, 2'b10, 1'b1, 0));

      // R8: an abandoned partial write never commits
      drive(1'b1, 1'b1, 1'b1, 36'h1AA);
      drive(1'b0, 1'b1, 1'b1, 36'h155);
      check("R8", {35'd0, mem_we}, 36'd0);
      drive(1'b1, 1'b0, 1'b0, '0);
      check("R8", {35'd0, mem_we}, 36'd0);
      drive(1'b0, 1'b0, 1'b0, '0);
      check("R8", {35'd0, mem_we}, 36'd0);

      // R6: wrap after last piece in 18-bit mode
      mode = 2'b01; big_endian = 1'b0;
      drive(1'b1, 1'b1, 1'b0, '0);
      drive(1'b0, 1'b1, 1'b0, '0);
      check("R6", {35'd0, word_done}, 36'd1);
      drive(1'b0, 1'b1, 1'b0, '0);
      check("R6", port_dout, exp_piece(mem_word, 2'b01, 1'b0, 0));
      drive(1'b0, 1'b0, 1'b0, '0);

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule